// File: doc/BRIEF.md
# Masked Memory Checksum Accumulator

This block forms the 16-bit checksum of a small program memory as a stream of addressed 12-bit words passes by. A start strobe clears the running total. Words then arrive one per cycle with a valid flag. Each word is added only if its address lies in the range counted for the current protection setting. A finish strobe closes the sum. It adds the configuration word after a fixed mask and, when protection is on, a 16-bit value packed from the low nibbles of the four user ID words.

The result appears on `sum_o` together with a one-cycle `done_o` pulse. It stays there until the next start. The parameter `USER_WORDS` gives the size of user memory, and with it the top user address that is never counted. The parameter `PROT_WORDS` gives how many words at the bottom of memory still count under protection. The block receives only the low nibble of each user ID, because no other bit takes part in the sum.

Top module: `cksum_accum`

## Requirements
- R1: After reset, `sum_o` is 0x0000 and `done_o` is low.
- R2: One cycle after `start_i`, `sum_o` reads 0x0000, `done_o` is low, and the running total is cleared.
- R3: With `prot_i` low, a valid word is added if its address is below `USER_WORDS-1`. The top user address (`USER_WORDS-1`) and every address at or above it are not added.
- R4: With `prot_i` high, a valid word is added only if its address is below `PROT_WORDS`. All other addresses are accepted but not added.
- R5: A cycle with `word_vld_i` low adds nothing, whatever `word_i` and `word_addr_i` carry.
- R6: `finish_i` adds `cfg_i` ANDed with 0x01C to the total.
- R7: With `prot_i` high, `finish_i` also adds {`id0_i`,`id1_i`,`id2_i`,`id3_i`}, with `id0_i` as the most significant nibble. With `prot_i` low the IDs have no effect on the result.
- R8: The sum is taken modulo 2^16, so carries above bit 15 are dropped.
- R9: `done_o` is high for exactly one cycle: the cycle after `finish_i`. The final `sum_o` is valid in that same cycle.
- R10: Once done, `sum_o` keeps its value until the next `start_i`, even if more words arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the total and the result |
| finish_i | input | 1 | Closes the sum with the configuration and ID terms |
| prot_i | input | 1 | Code protection on (1) or off (0) |
| word_vld_i | input | 1 | `word_i`/`word_addr_i` carry a memory word |
| word_addr_i | input | ADDR_W | Address of the presented word |
| word_i | input | WORD_W | 12-bit memory word |
| cfg_i | input | WORD_W | Configuration word |
| id0_i | input | ID_NIB | Low nibble of user ID 0 |
| id1_i | input | ID_NIB | Low nibble of user ID 1 |
| id2_i | input | ID_NIB | Low nibble of user ID 2 |
| id3_i | input | ID_NIB | Low nibble of user ID 3 |
| sum_o | output | SUM_W | Checksum result |
| done_o | output | 1 | One-cycle pulse when `sum_o` is final |

## Verification
The bench uses the default parameters: 256 user words, a 64-word window that still counts under protection, and a 9-bit address. With these values a full stream of all-ones words wraps the 16-bit sum many times, which exercises R8. The same stream also reaches the top user address and the configuration region just above it, which exercises the exclusions in R3 and R4. A blank stream with the configuration word at 0xFFF must give 0xEF1D with protection off. The protected vectors combine that stream with an ID pack whose addition overflows bit 15.

// File: rtl/cksum_accum.sv
module cksum_accum #(
  parameter int WORD_W     = 12,
  parameter int SUM_W      = 16,
  parameter int ID_NIB     = 4,
  parameter int USER_WORDS = 256,
  parameter int PROT_WORDS = 64,
  parameter logic [WORD_W-1:0] CFG_MASK = 12'h01C,
  parameter int ADDR_W     = $clog2(USER_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              finish_i,
  input  logic              prot_i,
  input  logic              word_vld_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] cfg_i,
  input  logic [ID_NIB-1:0] id0_i,
  input  logic [ID_NIB-1:0] id1_i,
  input  logic [ID_NIB-1:0] id2_i,
  input  logic [ID_NIB-1:0] id3_i,
  output logic [SUM_W-1:0]  sum_o,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(USER_WORDS - 1);
  localparam logic [ADDR_W-1:0] PROT_LIM = ADDR_W'(PROT_WORDS);

  logic [SUM_W-1:0] acc_q, sum_q, acc_nxt, word_term, cfg_term, id_term;
  logic             done_q, counted;

  assign counted   = prot_i ? (word_addr_i < PROT_LIM) : (word_addr_i < TOP_ADDR);
  assign word_term = (word_vld_i && counted) ? SUM_W'(word_i) : '0;
  assign cfg_term  = SUM_W'(cfg_i & CFG_MASK);
  assign id_term   = prot_i ? SUM_W'({id0_i, id1_i, id2_i, id3_i}) : '0;
  assign acc_nxt   = acc_q + word_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else if (finish_i) begin
      acc_q  <= acc_nxt;
      sum_q  <= acc_nxt + cfg_term + id_term;
      done_q <= 1'b1;
    end else begin
      acc_q  <= acc_nxt;
      done_q <= 1'b0;
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sum_o == '0 && !done_o));

  a_r9_done_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && !start_i) |=> done_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !finish_i) |=> !done_o);

  a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !finish_i) |=> $stable(sum_o));

  a_r5_idle_no_add: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_vld_i && !start_i && !finish_i) |=> $stable(acc_q));

  a_r3_top_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && !prot_i && word_addr_i >= TOP_ADDR && !start_i && !finish_i)
      |=> $stable(acc_q));

  a_r4_window_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && prot_i && word_addr_i >= PROT_LIM && !start_i && !finish_i)
      |=> $stable(acc_q));

endmodule

// File: tb/cksum_accum_bench.sv
module cksum_accum_bench;
  localparam int USER_WORDS = 256;
  localparam int ADDR_W = 9;

  typedef struct packed {
    logic        prot;
    logic [11:0] fill;
    logic [11:0] cfg;
    logic [15:0] ids;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'hFFF, 12'hFFF, 16'hDD89, 16'hEF1D},
    '{1'b1, 12'hFFF, 12'hFFF, 16'hDD89, 16'hDD65},
    '{1'b0, 12'h000, 12'h000, 16'h0000, 16'h0000},
    '{1'b0, 12'h001, 12'h008, 16'hFFFF, 16'h0107},
    '{1'b1, 12'h001, 12'h014, 16'h1234, 16'h1288},
    '{1'b0, 12'h100, 12'hFE3, 16'h0000, 16'hFF00},
    '{1'b1, 12'h0FF, 12'h01C, 16'hFFFF, 16'h3FDB}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, finish_i = 0, prot_i = 0, word_vld_i = 0;
  logic [ADDR_W-1:0] word_addr_i = '0;
  logic [11:0] word_i = '0, cfg_i = '0;
  logic [3:0] id0_i = 0, id1_i = 0, id2_i = 0, id3_i = 0;
  logic [15:0] sum_o;
  logic done_o;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  cksum_accum u_cksum_accum (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .finish_i(finish_i),
    .prot_i(prot_i), .word_vld_i(word_vld_i), .word_addr_i(word_addr_i),
    .word_i(word_i), .cfg_i(cfg_i), .id0_i(id0_i), .id1_i(id1_i),
    .id2_i(id2_i), .id3_i(id3_i), .sum_o(sum_o), .done_o(done_o)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic run_vec(vec_t v);
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    check("R2 start clears", sum_o, 16'h0000);
    prot_i = v.prot; cfg_i = v.cfg;
    {id0_i, id1_i, id2_i, id3_i} = v.ids;
    for (int a = 0; a < USER_WORDS; a++) begin
      if (a == 10) begin
        word_vld_i = 0; word_addr_i = '0; word_i = 12'hFFF;
        @(negedge clk);
      end
      word_vld_i = 1; word_addr_i = ADDR_W'(a);
      word_i = (a == USER_WORDS - 1) ? 12'h723 : v.fill;
      @(negedge clk);
    end
    word_addr_i = ADDR_W'(USER_WORDS); word_i = 12'hFFF;
    @(negedge clk) word_vld_i = 0; finish_i = 1;
    @(negedge clk) finish_i = 0;
    check("R9 done pulse", {15'd0, done_o}, 16'h0001);
    check(v.prot ? "R4 R5 R6 R7 R8 sum" : "R3 R5 R6 R7 R8 sum", sum_o, v.exp);
    @(negedge clk);
    check("R9 done falls", {15'd0, done_o}, 16'h0000);
    check("R10 holds", sum_o, v.exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sum", sum_o, 16'h0000);
    check("R1 reset done", {15'd0, done_o}, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    foreach (VECS[i]) run_vec(VECS[i]);
    // R10: words after done must not disturb the held result
    word_vld_i = 1; word_addr_i = '0; word_i = 12'h555; prot_i = 0;
    repeat (5) @(negedge clk);
    word_vld_i = 0;
    check("R10 holds after words", sum_o, VECS[NV-1].exp);
    // R6 alone: start then finish with no words
    cfg_i = 12'hFFF; prot_i = 1; {id0_i, id1_i, id2_i, id3_i} = 16'h0000;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    check("R2 start clears", sum_o, 16'h0000);
    finish_i = 1;
    @(negedge clk) finish_i = 0;
    check("R6 cfg mask only", sum_o, 16'h001C);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule